// File: doc/BRIEF.md
# Vector Register Redirection Table

This block sits in the operand-issue path of a scalar core that has been extended with vector operation. Software loads up to sixteen 16-bit redirection words into a small table. Each word names an architectural register by its 5-bit number and its class (integer or floating point). An operand that refers to that register is then steered to a wider physical register index. The operand is also tagged with a vector/scalar flag, an element-width code and a packed-SIMD flag.

Three lookup ports work in parallel: two for source operands and one for the destination. Each port compares its register number and class against every valid entry in the same cycle. When no entry matches, the operand passes through unchanged as a scalar of default width. A combinational read-back port returns any stored word together with its valid bit, so an operating system can save the table on a context switch and later restore it through the write port.

The parameter `SPLIT_CLASS` selects one of two layouts. In the unified layout, one table carries a class bit in every word. In the split layout, there are two tables, one per class, and each word trades the class bit for a 7-bit target index.

Top module: `vreg_remap_table`

## Requirements
- R1: After reset every entry is invalid: read-back reports valid = 0 and every lookup misses.
- R2: A write (`cfg_wr_en`) stores `cfg_wdata` in slot `cfg_idx` and marks it valid. Both read-back and lookups reflect the write from the next cycle on, and not in the cycle of the write.
- R3: Unified word layout, from bit 0 upward: bits [4:0] hold the key register number, [6:5] the element-width code, [7] the class (1 = integer, 0 = FP), [13:8] the 6-bit target index, [14] the vector flag (1 = vector) and [15] the packed-SIMD flag (1 = packed).
- R4: On a hit the element-width code and the packed flag are output exactly as stored. The code means 0 = 8-bit, 1 = default, 2 = half default, 3 = double default.
- R5: An entry matches only when both its key and its class equal those of the operand. An integer entry never redirects an FP operand with the same number, and an FP entry never redirects an integer operand.
- R6: On a miss the port outputs hit = 0, index = the register number zero-extended, vector = 0, width code = 1 and packed = 0.
- R7: An integer lookup of register 0 always misses, even when a valid entry holds that key. An FP lookup of register 0 can be redirected.
- R8: When several valid entries match the same operand, the entry in the lowest-numbered slot supplies the result.
- R9: A clear (`cfg_clr_en`) makes slot `cfg_idx` invalid from the next cycle on, while its stored word stays readable. When a write and a clear target the same slot in the same cycle, the clear wins.
- R10: The three lookup ports are independent: each gives its own result for its own operand in the same cycle.
- R11: Read-back returns the stored 16-bit word and the valid bit of slot `rd_idx` combinationally.
- R12: With `SPLIT_CLASS` = 1 there is one table per class, selected by `cfg_int`, `rd_int` and the operand class (1 = integer). The word keeps key [4:0], width [6:5], vector [14] and packed [15], holds a 7-bit target index in [13:7], and has no class bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write the word into the selected slot and set its valid bit |
| cfg_clr_en | input | 1 | Clear the valid bit of the selected slot |
| cfg_idx | input | IDX_W | Slot targeted by a write or clear |
| cfg_int | input | 1 | Table targeted by a write or clear in split layout (1 = integer) |
| cfg_wdata | input | 16 | Word to store |
| rd_idx | input | IDX_W | Slot to read back |
| rd_int | input | 1 | Table to read back in split layout (1 = integer) |
| rd_data | output | 16 | Stored word of the read-back slot |
| rd_valid | output | 1 | Valid bit of the read-back slot |
| lk_reg | input | NUM_PORTS*5 | Register number per lookup port |
| lk_int | input | NUM_PORTS | Operand class per port (1 = integer) |
| lk_hit | output | NUM_PORTS | An entry redirected this operand |
| lk_idx | output | NUM_PORTS*PHYS_W | Physical register index per port |
| lk_vec | output | NUM_PORTS | Vector flag per port |
| lk_ew | output | NUM_PORTS*2 | Element-width code per port |
| lk_pk | output | NUM_PORTS | Packed-SIMD flag per port |

## Verification
The hardest situation to reach from the ports is priority among duplicate matches. It only shows up when two valid slots carry the same key and class, and the lower-numbered one is loaded after the higher one. The stimulus writes slot 3 first and checks its result, then writes slot 1 with the same key and checks that slot 1 takes over. It then clears slot 1 and checks that slot 3 becomes visible again. The write-and-clear collision on one slot is produced in a single cycle, and its effect is observed through both the lookup port and read-back.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  localparam int ENTRY_W = 16;
  localparam int KEY_W   = 5;
  localparam int EW_W    = 2;
  localparam logic [EW_W-1:0] EW_DEFAULT = 2'd1;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [EW_W-1:0]  ew;
    logic             is_int;
    logic [6:0]       tgt;
    logic             vec;
    logic             pk;
  } entry_fields_t;

  // Field extraction for both word layouts.
  function automatic entry_fields_t unpack_entry(input logic [ENTRY_W-1:0] w,
                                                 input bit split);
    entry_fields_t f;
    f.key = w[4:0];
    f.ew  = w[6:5];
    f.vec = w[14];
    f.pk  = w[15];
    if (split) begin
      f.is_int = 1'b0;
      f.tgt    = w[13:7];
    end else begin
      f.is_int = w[7];
      f.tgt    = {1'b0, w[13:8]};
    end
    return f;
  endfunction

endpackage

// File: rtl/vrt_store.sv
module vrt_store
  import vrt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_BANKS   = 1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SLOTS      = NUM_BANKS * NUM_ENTRIES,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          clr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          bank,
  input  logic [ENTRY_W-1:0]            wdata,
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic                          rd_bank,
  output logic [ENTRY_W-1:0]            rd_data,
  output logic                          rd_valid,
  output logic [SLOTS-1:0][ENTRY_W-1:0] ent_o,
  output logic [SLOTS-1:0]              vld_o
);

  logic [SLOTS-1:0][ENTRY_W-1:0] ent_q, ent_d;
  logic [SLOTS-1:0]              vld_q, vld_d;
  logic [SLOT_W-1:0]             wslot, rslot;
  logic                          upd_en;

  // With a single bank the bank term multiplies to zero.
  always_comb begin
    wslot = SLOT_W'(idx) + SLOT_W'(bank) * SLOT_W'(NUM_ENTRIES);
    rslot = SLOT_W'(rd_idx) + SLOT_W'(rd_bank) * SLOT_W'(NUM_ENTRIES);
  end

  assign upd_en = wr_en | clr_en;

  always_comb begin
    ent_d = ent_q;
    vld_d = vld_q;
    if (wr_en) begin
      ent_d[wslot] = wdata;
      vld_d[wslot] = 1'b1;
    end
    if (clr_en) begin
      vld_d[wslot] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      vld_q <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
      vld_q <= vld_d;
    end
  end

  assign ent_o    = ent_q;
  assign vld_o    = vld_q;
  assign rd_data  = ent_q[rslot];
  assign rd_valid = vld_q[rslot];

  // R2: a plain write lands in the addressed slot one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> (vld_o[$past(wslot)] && ent_o[$past(wslot)] == $past(wdata)));

  // R9: a clear (even together with a write) leaves the slot invalid
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_o[$past(wslot)]);

  // R1: valid bits only move on a write or clear
  a_r1_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en) |=> $stable(vld_o));

endmodule

// File: rtl/vrt_match.sv
module vrt_match
  import vrt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_BANKS   = 1,
  parameter bit SPLIT_CLASS = 1'b0,
  parameter int PHYS_W      = 6,
  localparam int SLOTS      = NUM_BANKS * NUM_ENTRIES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SLOTS-1:0][ENTRY_W-1:0] ent,
  input  logic [SLOTS-1:0]              vld,
  input  logic [KEY_W-1:0]              reg_num,
  input  logic                          is_int,
  output logic                          hit_o,
  output logic [PHYS_W-1:0]             idx_o,
  output logic                          vec_o,
  output logic [EW_W-1:0]               ew_o,
  output logic                          pk_o
);

  localparam int BANK_STRIDE = (NUM_BANKS > 1) ? NUM_ENTRIES : 0;

  logic [NUM_ENTRIES-1:0] hitv;
  entry_fields_t          fsel;
  logic                   any_hit;
  logic                   x0_guard;

  // Parallel compare against every entry of the selected bank.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    entry_fields_t f;
    logic          cls_ok;
    always_comb begin
      f      = unpack_entry(ent[(is_int ? BANK_STRIDE : 0) + e], SPLIT_CLASS);
      cls_ok = SPLIT_CLASS ? 1'b1 : (f.is_int == is_int);
      hitv[e] = vld[(is_int ? BANK_STRIDE : 0) + e] && (f.key == reg_num) && cls_ok;
    end
  end

  // Lowest-numbered matching slot wins.
  always_comb begin
    fsel = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (hitv[e]) begin
        fsel = unpack_entry(ent[(is_int ? BANK_STRIDE : 0) + e], SPLIT_CLASS);
      end
    end
  end

  assign x0_guard = is_int && (reg_num == '0);
  assign any_hit  = (|hitv) && !x0_guard;

  always_comb begin
    if (any_hit) begin
      hit_o = 1'b1;
      idx_o = fsel.tgt[PHYS_W-1:0];
      vec_o = fsel.vec;
      ew_o  = fsel.ew;
      pk_o  = fsel.pk;
    end else begin
      hit_o = 1'b0;
      idx_o = PHYS_W'(reg_num);
      vec_o = 1'b0;
      ew_o  = EW_DEFAULT;
      pk_o  = 1'b0;
    end
  end

  // R7: integer register zero is never redirected
  a_r7_x0_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    (is_int && reg_num == '0) |-> (!hit_o && idx_o == '0 && !vec_o && !pk_o));

  // R6: a miss passes the operand through as a default-width scalar
  a_r6_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (idx_o == PHYS_W'(reg_num) && !vec_o && ew_o == 2'd1 && !pk_o));

  // R5: a hit needs at least one valid entry somewhere in the table
  a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (vld != '0));

endmodule

// File: rtl/vreg_remap_table.sv
module vreg_remap_table
  import vrt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  parameter bit SPLIT_CLASS = 1'b0,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int NUM_BANKS  = SPLIT_CLASS ? 2 : 1,
  localparam int PHYS_W     = SPLIT_CLASS ? 7 : 6,
  localparam int SLOTS      = NUM_BANKS * NUM_ENTRIES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic                        cfg_clr_en,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic                        cfg_int,
  input  logic [ENTRY_W-1:0]          cfg_wdata,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        rd_int,
  output logic [ENTRY_W-1:0]          rd_data,
  output logic                        rd_valid,
  input  logic [NUM_PORTS*KEY_W-1:0]  lk_reg,
  input  logic [NUM_PORTS-1:0]        lk_int,
  output logic [NUM_PORTS-1:0]        lk_hit,
  output logic [NUM_PORTS*PHYS_W-1:0] lk_idx,
  output logic [NUM_PORTS-1:0]        lk_vec,
  output logic [NUM_PORTS*EW_W-1:0]   lk_ew,
  output logic [NUM_PORTS-1:0]        lk_pk
);

  logic [SLOTS-1:0][ENTRY_W-1:0] ent;
  logic [SLOTS-1:0]              vld;

  vrt_store #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_BANKS   (NUM_BANKS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .clr_en   (cfg_clr_en),
    .idx      (cfg_idx),
    .bank     (cfg_int),
    .wdata    (cfg_wdata),
    .rd_idx   (rd_idx),
    .rd_bank  (rd_int),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ent_o    (ent),
    .vld_o    (vld)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    vrt_match #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .NUM_BANKS   (NUM_BANKS),
      .SPLIT_CLASS (SPLIT_CLASS),
      .PHYS_W      (PHYS_W)
    ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .ent     (ent),
      .vld     (vld),
      .reg_num (lk_reg[p*KEY_W +: KEY_W]),
      .is_int  (lk_int[p]),
      .hit_o   (lk_hit[p]),
      .idx_o   (lk_idx[p*PHYS_W +: PHYS_W]),
      .vec_o   (lk_vec[p]),
      .ew_o    (lk_ew[p*EW_W +: EW_W]),
      .pk_o    (lk_pk[p])
    );
  end

endmodule

// File: tb/vreg_remap_table_bench.sv
module vreg_remap_table_bench;

  localparam int K_IDX = 0, K_VEC = 1, K_EW = 2, K_PK = 3, K_HIT = 4, K_RD = 5, K_RV = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, s_wr_en, clr_en, cint;
  logic [3:0]  cidx, rd_idx;
  logic        rd_int;
  logic [15:0] wdata;
  logic [14:0] lk_reg;
  logic [2:0]  lk_int;

  logic [15:0] rd_data, s_rd_data;
  logic        rd_valid, s_rd_valid;
  logic [2:0]  hit, vec, pk, s_hit, s_vec, s_pk;
  logic [17:0] idx;
  logic [20:0] s_idx;
  logic [5:0]  ew, s_ew;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          dut;
    int          kind;
    int          port;
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  vreg_remap_table u_vreg_remap_table (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_clr_en(clr_en),
    .cfg_idx(cidx), .cfg_int(cint), .cfg_wdata(wdata),
    .rd_idx(rd_idx), .rd_int(rd_int), .rd_data(rd_data), .rd_valid(rd_valid),
    .lk_reg(lk_reg), .lk_int(lk_int), .lk_hit(hit), .lk_idx(idx),
    .lk_vec(vec), .lk_ew(ew), .lk_pk(pk)
  );

  vreg_remap_table #(.SPLIT_CLASS(1'b1)) u_vreg_remap_table_split (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(s_wr_en), .cfg_clr_en(1'b0),
    .cfg_idx(cidx), .cfg_int(cint), .cfg_wdata(wdata),
    .rd_idx(rd_idx), .rd_int(rd_int), .rd_data(s_rd_data), .rd_valid(s_rd_valid),
    .lk_reg(lk_reg), .lk_int(lk_int), .lk_hit(s_hit), .lk_idx(s_idx),
    .lk_vec(s_vec), .lk_ew(s_ew), .lk_pk(s_pk)
  );

  function automatic logic [15:0] mk(int key, int w, int ty, int tgt, int v, int p);
    return {p[0], v[0], tgt[5:0], ty[0], w[1:0], key[4:0]};
  endfunction

  function automatic logic [15:0] smk(int key, int w, int tgt, int v, int p);
    return {p[0], v[0], tgt[6:0], w[1:0], key[4:0]};
  endfunction

  function automatic logic [15:0] got(int dut, int kind, int p);
    case (kind)
      K_IDX: return dut == 0 ? 16'(idx[p*6 +: 6]) : 16'(s_idx[p*7 +: 7]);
      K_VEC: return dut == 0 ? 16'(vec[p]) : 16'(s_vec[p]);
      K_EW:  return dut == 0 ? 16'(ew[p*2 +: 2]) : 16'(s_ew[p*2 +: 2]);
      K_PK:  return dut == 0 ? 16'(pk[p]) : 16'(s_pk[p]);
      K_HIT: return dut == 0 ? 16'(hit[p]) : 16'(s_hit[p]);
      K_RD:  return dut == 0 ? rd_data : s_rd_data;
      default: return dut == 0 ? 16'(rd_valid) : 16'(s_rd_valid);
    endcase
  endfunction

  task automatic expect_item(int dut, int kind, int p, logic [15:0] v, string req);
    exp_t it;
    it.dut = dut; it.kind = kind; it.port = p; it.val = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic expect_lk(int dut, int p, int i, int v, int w, int pkv, int h, string req);
    expect_item(dut, K_IDX, p, 16'(i), req);
    expect_item(dut, K_VEC, p, 16'(v), req);
    expect_item(dut, K_EW,  p, 16'(w), req);
    expect_item(dut, K_PK,  p, 16'(pkv), req);
    expect_item(dut, K_HIT, p, 16'(h), req);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    wr_en = 1'b0; s_wr_en = 1'b0; clr_en = 1'b0;
  endtask

  task automatic set_lk(int p, int r, int i);
    lk_reg[p*5 +: 5] = 5'(r);
    lk_int[p]        = i[0];
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      logic [15:0] g;
      it = q.pop_front();
      g  = got(it.dut, it.kind, it.port);
      checks++;
      if (g !== it.val) begin
        errors++;
        $display("FAIL %s dut=%0d kind=%0d port=%0d actual=%h expected=%h",
                 it.req, it.dut, it.kind, it.port, g, it.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; s_wr_en = 1'b0; clr_en = 1'b0; cint = 1'b1;
    cidx = '0; rd_idx = '0; rd_int = 1'b1; wdata = '0; lk_reg = '0; lk_int = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 / R6: empty table, every lookup misses
    step();
    set_lk(0, 5, 1); set_lk(1, 31, 1); set_lk(2, 12, 0);
    expect_lk(0, 0, 5, 0, 1, 0, 0, "R1");
    expect_lk(0, 1, 31, 0, 1, 0, 0, "R6");
    expect_lk(0, 2, 12, 0, 1, 0, 0, "R6");
    expect_item(0, K_RV, 0, 16'd0, "R1");

    // R2: same-cycle lookup still sees the old contents
    step();
    wr_en = 1'b1; cidx = 4'd3; wdata = mk(5, 2, 1, 40, 1, 0);
    rd_idx = 4'd3;
    expect_lk(0, 0, 5, 0, 1, 0, 0, "R2");
    expect_item(0, K_RV, 0, 16'd0, "R2");

    // R2/R3/R4/R5/R11/R10
    step();
    set_lk(0, 5, 1); set_lk(1, 5, 0); set_lk(2, 7, 1);
    expect_lk(0, 0, 40, 1, 2, 0, 1, "R3");
    expect_lk(0, 1, 5, 0, 1, 0, 0, "R5");
    expect_lk(0, 2, 7, 0, 1, 0, 0, "R10");
    expect_item(0, K_RD, 0, mk(5, 2, 1, 40, 1, 0), "R11");
    expect_item(0, K_RV, 0, 16'd1, "R2");

    // R8: lower slot with the same key takes over
    step();
    wr_en = 1'b1; cidx = 4'd1; wdata = mk(5, 3, 1, 50, 0, 1);
    step();
    set_lk(0, 5, 1); set_lk(1, 5, 1); set_lk(2, 5, 0);
    expect_lk(0, 0, 50, 0, 3, 1, 1, "R8");
    expect_lk(0, 1, 50, 0, 3, 1, 1, "R4");
    expect_lk(0, 2, 5, 0, 1, 0, 0, "R5");

    // R7: integer x0 entry and FP f0 entry
    step();
    wr_en = 1'b1; cidx = 4'd0; wdata = mk(0, 0, 1, 33, 1, 0);
    step();
    wr_en = 1'b1; cidx = 4'd2; wdata = mk(0, 0, 0, 34, 1, 1);
    step();
    set_lk(0, 0, 1); set_lk(1, 0, 0); set_lk(2, 5, 1);
    expect_lk(0, 0, 0, 0, 1, 0, 0, "R7");
    expect_lk(0, 1, 34, 1, 0, 1, 1, "R7");
    expect_lk(0, 2, 50, 0, 3, 1, 1, "R10");

    // R9: clear slot 1, slot 3 shows through again, word still readable
    step();
    clr_en = 1'b1; cidx = 4'd1;
    step();
    rd_idx = 4'd1;
    set_lk(0, 5, 1);
    expect_lk(0, 0, 40, 1, 2, 0, 1, "R9");
    expect_item(0, K_RV, 0, 16'd0, "R9");
    expect_item(0, K_RD, 0, mk(5, 3, 1, 50, 0, 1), "R9");

    // R9: write and clear on the same slot in one cycle, clear wins
    step();
    wr_en = 1'b1; clr_en = 1'b1; cidx = 4'd4; wdata = mk(9, 1, 1, 60, 1, 0);
    step();
    rd_idx = 4'd4;
    set_lk(0, 9, 1);
    expect_lk(0, 0, 9, 0, 1, 0, 0, "R9");
    expect_item(0, K_RV, 0, 16'd0, "R9");

    // R12: split layout, one table per class, 7-bit targets
    step();
    s_wr_en = 1'b1; cint = 1'b1; cidx = 4'd0; wdata = smk(6, 0, 100, 1, 0);
    step();
    s_wr_en = 1'b1; cint = 1'b0; cidx = 4'd0; wdata = smk(6, 3, 7, 0, 1);
    step();
    s_wr_en = 1'b1; cint = 1'b1; cidx = 4'd1; wdata = smk(0, 2, 90, 1, 0);
    step();
    set_lk(0, 6, 1); set_lk(1, 6, 0); set_lk(2, 0, 1);
    rd_idx = 4'd0; rd_int = 1'b1;
    expect_lk(1, 0, 100, 1, 0, 0, 1, "R12");
    expect_lk(1, 1, 7, 0, 3, 1, 1, "R12");
    expect_lk(1, 2, 0, 0, 1, 0, 0, "R7");
    expect_item(1, K_RD, 0, smk(6, 0, 100, 1, 0), "R12");
    expect_item(1, K_RV, 0, 16'd1, "R12");
    step();
    rd_int = 1'b0;
    expect_item(1, K_RD, 0, smk(6, 3, 7, 0, 1), "R12");

    step();
    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule